// File: doc/BRIEF.md
# DMA Controller Register Front End

This block holds the programming state of a four-channel DMA controller. It sits on a byte-wide I/O port with a 4-bit address and separate read and write strobes. The lower half of the address space reaches the per-channel 16-bit start address and transfer count registers. Each of these is reached one byte at a time through a shared byte pointer. The upper half holds the shared control registers.

Most control registers take a single-byte command. In that byte, a small select field picks a channel and one value bit sets or clears that channel's mask bit or software request bit. Other writes load the command byte or a channel's mode byte, reset the byte pointer, clear or load every mask bit at once, or perform a master clear. The transfer engine uses the outputs: the channel mask, the mode bytes, the request bits and the command byte.

Top module: `dma_regfile`

## Requirements
- R1: After synchronous reset, chan_mask is 4'hF, sw_req and cmd_byte are 0, every mode byte and every channel register is 0, and the byte pointer selects the low byte. Reads of offsets 0x8 and 0xD return 0.
- R2: A write to offset 0x8 stores the whole data byte in cmd_byte at the next rising edge.
- R3: A write to offset 0xA changes only the mask bit of the channel in data bits 1:0, setting it to data bit 2. The other mask bits keep their values.
- R4: A write to offset 0x9 changes only the request bit of the channel in data bits 1:0, setting it to data bit 2.
- R5: A write to offset 0xB stores the whole data byte as the mode of the channel in data bits 1:0. Channel n's mode appears on chan_mode bits 8n+7:8n.
- R6: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask from data bits 3:0.
- R7: Offset 2n is channel n's 16-bit start address and offset 2n+1 is its count. A read or write there reaches the low byte when the byte pointer is clear and the high byte when it is set. Each such access toggles the pointer. Read data is combinational.
- R8: Any write to offset 0xC clears the byte pointer, so the next channel-register access reaches the low byte.
- R9: A write to offset 0xD returns the mask, request, command and pointer to their R1 values. Mode bytes and channel registers are kept.
- R10: A read of offset 0x9, 0xA, 0xB, 0xC, 0xE or 0xF raises rd_err in the same cycle with rdata 0. A read with no write changes no state apart from the pointer toggle of R7.
- R11: When both strobes are asserted at a channel offset, rdata shows the byte before the write, the write lands in that same byte, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational from addr |
| rd_err | output | 1 | Read of a write-only offset |
| chan_mask | output | 4 | Per-channel mask, 1 = masked |
| sw_req | output | 4 | Per-channel software request bits |
| chan_mode | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| cmd_byte | output | 8 | Command byte |

## Verification
Two functions can act in the same cycle: a read and a write of the same channel register, since both strobes share one address and one byte pointer. The bench raises both strobes together at a channel offset. It checks that the combinational read data is the old byte and that the pointer advanced only once, by reading the next byte afterwards. It then clears the pointer and reads back to confirm that the new value landed in the byte that was selected.

// File: rtl/dma_rf_pkg.sv
// Package: shared offsets and helpers for the DMA register front end.
// Assumes the control page is the upper eight offsets (addr[3] = 1) and is
// decoded on addr[2:0].
package dma_rf_pkg;
    localparam int OFS_STATCMD = 0;   // 0x8
    localparam int OFS_REQ     = 1;   // 0x9
    localparam int OFS_SMASK   = 2;   // 0xA
    localparam int OFS_MODE    = 3;   // 0xB
    localparam int OFS_CLRPTR  = 4;   // 0xC
    localparam int OFS_MCLR    = 5;   // 0xD
    localparam int OFS_CLRMASK = 6;   // 0xE
    localparam int OFS_ALLMASK = 7;   // 0xF

    // True for control offsets that cannot be read.
    function automatic logic is_write_only(input logic [2:0] ofs);
        return !(ofs == 3'(OFS_STATCMD) || ofs == 3'(OFS_MCLR));
    endfunction
endpackage

// File: rtl/dma_rf_decode.sv
// Module: address decode. Turns the offset and strobes into a channel-page
// access flag, one-hot control write strobes and the illegal-read flag.
// Assumes a single access per cycle on one shared address.
module dma_rf_decode
    import dma_rf_pkg::*;
(
    input  logic [3:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic       chan_acc,
    output logic       chan_wr,
    output logic [7:0] ctl_wr,
    output logic       rd_err
);
    // Decode page and strobes.
    always_comb begin
        chan_acc = !addr[3] && (wr_en || rd_en);
        chan_wr  = !addr[3] && wr_en;
        ctl_wr   = (addr[3] && wr_en) ? (8'b1 << addr[2:0]) : 8'b0;
        rd_err   = rd_en && addr[3] && is_write_only(addr[2:0]);
    end
endmodule

// File: rtl/dma_rf_chanregs.sv
// Module: per-channel start address and count registers, 16 bits each,
// reached a byte at a time. Register index equals addr[2:0]: even = address,
// odd = count. Assumes the byte pointer comes from the control block.
module dma_rf_chanregs #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            chan_wr,
    input  logic [$clog2(2*NCH)-1:0]        ridx,
    input  logic                            hi_ptr,
    input  logic [DW-1:0]                   wdata,
    output logic [DW-1:0]                   rbyte
);
    localparam int NREG = 2 * NCH;
    localparam int RW   = 2 * DW;

    logic [RW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Byte-wide update of one 16-bit register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (chan_wr && ridx == i[$clog2(NREG)-1:0]) begin
                if (hi_ptr) regs[i][RW-1:DW] <= wdata;
                else        regs[i][DW-1:0]  <= wdata;
            end
        end
    end

    // Select the addressed byte for reading.
    always_comb rbyte = hi_ptr ? regs[ridx][RW-1:DW] : regs[ridx][DW-1:0];

    assert_byte_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_wr |=> (($past(hi_ptr) ? regs[$past(ridx)][RW-1:DW]
                                    : regs[$past(ridx)][DW-1:0]) == $past(wdata)));
endmodule

// File: rtl/dma_rf_ctrl.sv
// Module: shared control state: mask, software requests, command, mode
// bytes and the byte pointer. Reset and master clear share one clear path;
// mode bytes are cleared by reset only. Assumes one-hot ctl_wr.
module dma_rf_ctrl
    import dma_rf_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ctl_wr,
    input  logic              chan_acc,
    input  logic [DW-1:0]     wdata,
    output logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    req,
    output logic [DW-1:0]     cmd,
    output logic [NCH*DW-1:0] mode_flat,
    output logic              hi_ptr
);
    localparam int CW = $clog2(NCH);

    logic          clr_all;
    logic [CW-1:0] sel;
    logic          bitval;

    // Shared clear condition and command-byte fields.
    always_comb begin
        clr_all = !rst_n || ctl_wr[OFS_MCLR];
        sel     = wdata[CW-1:0];
        bitval  = wdata[2];
    end

    // Channel mask: clear-all, load-all or single-bit update.
    always_ff @(posedge clk) begin
        if (clr_all)                  mask <= '1;
        else if (ctl_wr[OFS_CLRMASK]) mask <= '0;
        else if (ctl_wr[OFS_ALLMASK]) mask <= wdata[NCH-1:0];
        else if (ctl_wr[OFS_SMASK])   mask[sel] <= bitval;
    end

    // Software request bits.
    always_ff @(posedge clk) begin
        if (clr_all)              req <= '0;
        else if (ctl_wr[OFS_REQ]) req[sel] <= bitval;
    end

    // Command byte.
    always_ff @(posedge clk) begin
        if (clr_all)                  cmd <= '0;
        else if (ctl_wr[OFS_STATCMD]) cmd <= wdata;
    end

    // Byte pointer: cleared explicitly, toggled by channel accesses.
    always_ff @(posedge clk) begin
        if (clr_all || ctl_wr[OFS_CLRPTR]) hi_ptr <= 1'b0;
        else if (chan_acc)                 hi_ptr <= !hi_ptr;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_mode
        // Mode byte of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_flat[i*DW +: DW] <= '0;
            else if (ctl_wr[OFS_MODE] && sel == i[CW-1:0])
                mode_flat[i*DW +: DW] <= wdata;
        end
    end

    assert_single_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr[OFS_SMASK] |=> (mask[$past(sel)] == $past(bitval))
                              && ($countones(mask ^ $past(mask)) <= 1));
    assert_clear_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr[OFS_CLRMASK] |=> (mask == '0));
    assert_ptr_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_acc |=> (hi_ptr != $past(hi_ptr)));
    assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr[OFS_CLRPTR] |=> !hi_ptr);
    assert_master_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr[OFS_MCLR] |=> (mask == '1) && (req == '0) && (cmd == '0) && !hi_ptr);
endmodule

// File: rtl/dma_regfile.sv
// Module: top of the DMA register front end. Joins decode, channel
// registers and control state, and muxes read data. Status and temporary
// registers have no source in this block and read as zero.
module dma_regfile
    import dma_rf_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    output logic              rd_err,
    output logic [NCH-1:0]    chan_mask,
    output logic [NCH-1:0]    sw_req,
    output logic [NCH*DW-1:0] chan_mode,
    output logic [DW-1:0]     cmd_byte
);
    localparam int IW = $clog2(2 * NCH);
    localparam logic [DW-1:0] STATUS_VAL = '0;
    localparam logic [DW-1:0] TEMP_VAL   = '0;

    logic          chan_acc, chan_wr, hi_ptr;
    logic [7:0]    ctl_wr;
    logic [DW-1:0] chan_byte;

    dma_rf_decode u_dec (
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .chan_acc(chan_acc), .chan_wr(chan_wr), .ctl_wr(ctl_wr), .rd_err(rd_err)
    );

    dma_rf_chanregs #(.NCH(NCH), .DW(DW)) u_chan (
        .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr), .ridx(addr[IW-1:0]),
        .hi_ptr(hi_ptr), .wdata(wdata), .rbyte(chan_byte)
    );

    dma_rf_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .chan_acc(chan_acc),
        .wdata(wdata), .mask(chan_mask), .req(sw_req), .cmd(cmd_byte),
        .mode_flat(chan_mode), .hi_ptr(hi_ptr)
    );

    // Read data mux by page and control offset.
    always_comb begin
        if (!addr[3])                         rdata = chan_byte;
        else if (addr[2:0] == 3'(OFS_STATCMD)) rdata = STATUS_VAL;
        else if (addr[2:0] == 3'(OFS_MCLR))    rdata = TEMP_VAL;
        else                                   rdata = '0;
    end

    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rdata == '0));
    assert_read_no_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> $stable(chan_mask) && $stable(sw_req)
                              && $stable(cmd_byte) && $stable(chan_mode));
    assert_one_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_wr) && !(chan_wr && (ctl_wr != '0)));
endmodule

// File: tb/tb_dma_regfile.sv
// Bench: behavioural reference model updated per access and compared with
// the outputs on every falling edge; read data checked during each access.
module tb_dma_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  addr = 0;
    logic [7:0]  wdata = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  rdata;
    logic        rd_err;
    logic [3:0]  chan_mask, sw_req;
    logic [31:0] chan_mode;
    logic [7:0]  cmd_byte;

    int checks = 0, errors = 0;
    bit run_cmp = 0, done = 0;

    // Reference model state.
    int m_mask, m_req, m_cmd, m_ptr;
    int m_mode[4];
    int m_reg[8];

    dma_regfile dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .rd_err(rd_err),
        .chan_mask(chan_mask), .sw_req(sw_req), .chan_mode(chan_mode),
        .cmd_byte(cmd_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = 15; m_req = 0; m_cmd = 0; m_ptr = 0;
        for (int i = 0; i < 4; i++) m_mode[i] = 0;
        for (int i = 0; i < 8; i++) m_reg[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; wr_en = 0; rd_en = 0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk); rst_n = 1; run_cmp = 1;
    endtask

    // One bus access; checks read data and error, then updates the model.
    task automatic acc(input int a, input int d, input bit w, input bit r, input string tag);
        int exp_rd, exp_err, sel;
        @(negedge clk);
        addr = 4'(a); wdata = 8'(d); wr_en = w; rd_en = r;
        #1;
        if (r) begin
            if (a < 8) exp_rd = m_ptr ? (m_reg[a] >> 8) & 255 : m_reg[a] & 255;
            else       exp_rd = 0;
            exp_err = (a >= 8 && a != 8 && a != 13) ? 1 : 0;
            chk({tag, " rdata"}, int'(rdata), exp_rd);
            chk({tag, " rd_err"}, int'(rd_err), exp_err);
        end
        @(posedge clk);
        sel = d & 3;
        if (w) begin
            case (a)
                8:  m_cmd = d & 255;
                9:  m_req = ((d >> 2) & 1) ? (m_req | (1 << sel)) : (m_req & ~(1 << sel));
                10: m_mask = ((d >> 2) & 1) ? (m_mask | (1 << sel)) : (m_mask & ~(1 << sel));
                11: m_mode[sel] = d & 255;
                12: m_ptr = 0;
                13: begin m_mask = 15; m_req = 0; m_cmd = 0; m_ptr = 0; end
                14: m_mask = 0;
                15: m_mask = d & 15;
                default: begin
                    if (m_ptr) m_reg[a] = (m_reg[a] & 255) | ((d & 255) << 8);
                    else       m_reg[a] = (m_reg[a] & 65280) | (d & 255);
                end
            endcase
        end
        if (a < 8 && (w || r)) m_ptr = m_ptr ^ 1;
        #1; wr_en = 0; rd_en = 0;
    endtask

    // Compare registered outputs with the model on every clock.
    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            chk("R3 R6 R9 chan_mask", int'(chan_mask), m_mask);
            chk("R4 R9 sw_req", int'(sw_req), m_req);
            chk("R2 R9 cmd_byte", int'(cmd_byte), m_cmd);
            for (int i = 0; i < 4; i++)
                chk("R5 chan_mode", int'(chan_mode[i*8 +: 8]), m_mode[i]);
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-reqs: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state; status and temporary read as zero
        chk("R1 mask after reset", int'(chan_mask), 15);
        acc(8, 0, 0, 1, "R1");
        acc(13, 0, 0, 1, "R1");
        acc(0, 0, 0, 1, "R1");
        // R2: command byte
        acc(8, 'hA5, 1, 0, "R2");
        acc(8, 'h3C, 1, 0, "R2");
        // R3: single mask bit
        acc(10, 'h01, 1, 0, "R3");
        acc(10, 'h03, 1, 0, "R3");
        acc(10, 'h06, 1, 0, "R3");
        acc(10, 'h07, 1, 0, "R3");
        // R4: request bits
        acc(9, 'h07, 1, 0, "R4");
        acc(9, 'h05, 1, 0, "R4");
        acc(9, 'h01, 1, 0, "R4");
        chk("R4 sw_req pattern", int'(sw_req), 8);
        // R5: mode bytes
        acc(11, 'h4B, 1, 0, "R5");
        acc(11, 'h94, 1, 0, "R5");
        acc(11, 'h56, 1, 0, "R5");
        chk("R5 channel 3 mode", int'(chan_mode[31:24]), 'h4B);
        // R6: load all / clear all mask
        acc(15, 'hFA, 1, 0, "R6");
        chk("R6 load all", int'(chan_mask), 'hA);
        acc(14, 'h00, 1, 0, "R6");
        // R7: channel registers, write then read both bytes
        acc(12, 0, 1, 0, "R8");
        for (int i = 0; i < 8; i++) begin
            acc(i, (i * 37 + 5) & 255, 1, 0, "R7");
            acc(i, (i * 91 + 17) & 255, 1, 0, "R7");
        end
        for (int i = 0; i < 8; i++) begin
            acc(i, 0, 0, 1, "R7");
            acc(i, 0, 0, 1, "R7");
        end
        // R8: pointer clear mid-pair
        acc(4, 'h34, 1, 0, "R8");
        acc(12, 0, 1, 0, "R8");
        acc(4, 0, 0, 1, "R8");
        chk("R8 low byte after clear", int'(m_ptr), 1);
        // R9: master clear with pointer high; modes kept
        acc(9, 'h06, 1, 0, "R9");
        acc(13, 0, 1, 0, "R9");
        chk("R9 mode kept", int'(chan_mode[7:0]), 'h94);
        acc(6, 0, 0, 1, "R9");
        // R10: illegal reads, pointer left high across them
        for (int a = 9; a < 16; a++) begin
            if (a != 13) acc(a, 0, 0, 1, "R10");
        end
        acc(6, 0, 0, 1, "R10");
        acc(12, 0, 1, 0, "R10");
        acc(0, 0, 0, 1, "R10");
        acc(12, 0, 0, 1, "R10");
        acc(0, 0, 0, 1, "R10");
        // R11: read and write together at a channel offset
        acc(12, 0, 1, 0, "R11");
        acc(2, 'hEE, 1, 1, "R11");
        acc(2, 0, 0, 1, "R11");
        acc(12, 0, 1, 0, "R11");
        acc(2, 0, 0, 1, "R11");
        // R1: reset again after activity
        do_reset();
        acc(3, 0, 0, 1, "R1");
        chk("R1 mode cleared", int'(chan_mode), 0);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule